// File: doc/BRIEF.md
# Reset Sequencer with Pulse Qualification and Release Stretching

This block produces the reset outputs for a chip from three active-low, asynchronous request inputs. The inputs are a power-on request, a hard request and a soft request. The power-on request takes effect at once, with no clock. The hard and soft requests take effect only when they stay low for a minimum number of reference clock cycles, so shorter glitches are dropped. Every count is made in cycles of the single reference clock `clk`.

There are three outputs. Two are pull-down enables for the open-drain hard and soft reset pins; a high level on one means its pin is driven low. The third is an active-high internal core reset. Each output stays asserted for a fixed hold time after the request that caused it goes away. A newer request restarts that hold from zero. Power-on reaches all three outputs. Hard reaches all three. Soft reaches only the soft pin. All release paths pass through a two-flop synchronizer before any counting begins. The power-on synchronizer sets asynchronously and clears on clock edges.

Top module: `reset_sequencer`

## Requirements
- R1: While `por_n` is low, `hard_pull_en`, `soft_pull_en` and `core_rst` are all 1. They go to 1 as soon as `por_n` falls, before any clock edge, including when `por_n` falls while a hold is already running.
- R2: After `por_n` rises, all three outputs stay 1 through the 4097th rising clock edge (SYNC_STAGES-1+PIN_HOLD with defaults 2 and 4096) and are 0 after the 4098th edge.
- R3: A low pulse on `hard_n` or `soft_n` that lasts only 3 rising edges (fewer than MIN_WIDTH=4) changes none of the outputs.
- R4: When `hard_n` or `soft_n` stays low for 4 or more rising edges, the outputs it controls are 0 after the 5th edge counted from the fall and 1 after the 6th edge (SYNC_STAGES+MIN_WIDTH).
- R5: After a qualified hard request is released, `hard_pull_en`, `soft_pull_en` and `core_rst` stay 1 through the 4097th edge and are 0 after the 4098th edge. The same timing applies to `soft_pull_en` after a qualified soft request is released.
- R6: A hard request also asserts the soft pin: whenever `hard_pull_en` is 1, `soft_pull_en` is 1.
- R7: A soft request never asserts `hard_pull_en` or `core_rst`.
- R8: A new qualified request that arrives while a hold is counting restarts that hold. The release is then timed from the newer request's release.
- R9: A power-on request during a hard hold restarts every hold, and release is timed from the rise of `por_n` as in R2.
- R10: A qualified soft request during a hard hold does not move the release of `hard_pull_en` or `core_rst`. It only extends `soft_pull_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock used for all width and hold counts |
| por_n | input | 1 | Power-on reset request, active low, asynchronous |
| hard_n | input | 1 | Hard reset request, active low, asynchronous, width-qualified |
| soft_n | input | 1 | Soft reset request, active low, asynchronous, width-qualified |
| hard_pull_en | output | 1 | 1 drives the open-drain hard reset pin low |
| soft_pull_en | output | 1 | 1 drives the open-drain soft reset pin low |
| core_rst | output | 1 | Active-high internal reset for the hard domain |

## Verification
The bench drives hard and soft pulses of 3, 4, 5 and 8 cycles, plus randomly chosen soft widths from 1 to 7. These show where the width filter passes a request and where it drops one, and they fix the exact assertion latency. It measures release timing at the cycle before and the cycle after the expected edge, after power-on, after a hard request and after a soft request. This separates a correct hold length from one that is off by one. It also overlaps requests: a second hard request, a power-on during a hard hold, and a soft request during a hard hold. These show whether a restart really resets the hold, and whether soft stays out of the hard domain.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;
  localparam int REQ_COUNT = 2;
  typedef enum logic [0:0] {
    REQ_HARD = 1'b0,
    REQ_SOFT = 1'b1
  } req_idx_e;
endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
  parameter int STAGES    = 2,
  parameter bit ASYNC_SET = 1'b0
) (
  input  logic clk,
  input  logic req_n,
  output logic req_o
);
  logic [STAGES-1:0] ff;

  generate
    if (ASYNC_SET) begin : g_async
      // assert immediately, release through the chain
      always_ff @(posedge clk or negedge req_n) begin
        if (!req_n) ff <= '1;
        else        ff <= {ff[STAGES-2:0], 1'b0};
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        ff <= {ff[STAGES-2:0], ~req_n};
      end
    end
  endgenerate

  assign req_o = ff[STAGES-1];
endmodule

// File: rtl/rstseq_width.sv
module rstseq_width #(
  parameter int MIN_W = 4
) (
  input  logic clk,
  input  logic clr,
  input  logic req_i,
  output logic qual_o
);
  localparam int CW = $clog2(MIN_W) + 1;
  localparam logic [CW-1:0] LAST = CW'(MIN_W - 1);

  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (clr || !req_i)  run <= '0;
    else if (run != LAST) run <= run + 1'b1;
  end

  assign qual_o = req_i && (run == LAST);

  // R3
  qual_width_chk: assert property (@(posedge clk) disable iff (clr)
    $rose(qual_o) |-> ($past(req_i) && $past(req_i, 2) && $past(req_i, 3)));
endmodule

// File: rtl/rstseq_stretch.sv
module rstseq_stretch #(
  parameter int HOLD = 4096
) (
  input  logic clk,
  input  logic apply,
  input  logic hold_req_i,
  output logic on_o
);
  localparam int CW = (HOLD > 2) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic          on_q;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or posedge apply) begin
    if (apply) begin
      on_q <= 1'b1;
      cnt  <= '0;
    end else if (hold_req_i) begin
      on_q <= 1'b1;
      cnt  <= '0;
    end else if (on_q) begin
      if (cnt == LAST) on_q <= 1'b0;
      else             cnt  <= cnt + 1'b1;
    end
  end

  assign on_o = on_q;

  // R4
  req_sets_out_chk: assert property (@(posedge clk) disable iff (apply)
    hold_req_i |=> on_q);

  // R5
  release_quiet_chk: assert property (@(posedge clk) disable iff (apply)
    $fell(on_q) |-> $past(!hold_req_i));
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
  import rstseq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_WIDTH   = 4,
  parameter int PIN_HOLD    = 4096,
  parameter int CORE_HOLD   = 4096
) (
  input  logic clk,
  input  logic por_n,
  input  logic hard_n,
  input  logic soft_n,
  output logic hard_pull_en,
  output logic soft_pull_en,
  output logic core_rst
);
  logic                 por_busy;
  logic [REQ_COUNT-1:0] req_n_vec;
  logic [REQ_COUNT-1:0] req_s;
  logic [REQ_COUNT-1:0] qual;

  rstseq_sync #(.STAGES(SYNC_STAGES), .ASYNC_SET(1'b1)) u_por_sync (
    .clk   (clk),
    .req_n (por_n),
    .req_o (por_busy)
  );

  assign req_n_vec[REQ_HARD] = hard_n;
  assign req_n_vec[REQ_SOFT] = soft_n;

  for (genvar g = 0; g < REQ_COUNT; g++) begin : g_req
    rstseq_sync #(.STAGES(SYNC_STAGES), .ASYNC_SET(1'b0)) u_sync (
      .clk   (clk),
      .req_n (req_n_vec[g]),
      .req_o (req_s[g])
    );
    rstseq_width #(.MIN_W(MIN_WIDTH)) u_width (
      .clk    (clk),
      .clr    (por_busy),
      .req_i  (req_s[g]),
      .qual_o (qual[g])
    );
  end

  // hard domain covers the hard pin; soft pin sees hard and soft
  rstseq_stretch #(.HOLD(PIN_HOLD)) u_hard_pin (
    .clk        (clk),
    .apply      (por_busy),
    .hold_req_i (qual[REQ_HARD]),
    .on_o       (hard_pull_en)
  );

  rstseq_stretch #(.HOLD(PIN_HOLD)) u_soft_pin (
    .clk        (clk),
    .apply      (por_busy),
    .hold_req_i (qual[REQ_HARD] | qual[REQ_SOFT]),
    .on_o       (soft_pull_en)
  );

  rstseq_stretch #(.HOLD(CORE_HOLD)) u_core (
    .clk        (clk),
    .apply      (por_busy),
    .hold_req_i (qual[REQ_HARD]),
    .on_o       (core_rst)
  );

  // R6
  hard_in_soft_chk: assert property (@(posedge clk) disable iff (por_busy)
    hard_pull_en |-> soft_pull_en);
endmodule

// File: tb/reset_sequencer_bench.sv
module reset_sequencer_bench;
  localparam int SYNC     = 2;
  localparam int MIN_W    = 4;
  localparam int HOLD     = 4096;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic por_n = 1'b1;
  logic hard_n = 1'b1;
  logic soft_n = 1'b1;
  logic hard_pull_en, soft_pull_en, core_rst;
  int tests = 0;
  int fails = 0;

  always #5 clk = ~clk;

  reset_sequencer #(
    .SYNC_STAGES(SYNC), .MIN_WIDTH(MIN_W), .PIN_HOLD(HOLD), .CORE_HOLD(HOLD)
  ) u_reset_sequencer (
    .clk(clk), .por_n(por_n), .hard_n(hard_n), .soft_n(soft_n),
    .hard_pull_en(hard_pull_en), .soft_pull_en(soft_pull_en), .core_rst(core_rst)
  );

  function automatic int rise_edges();
    return SYNC + MIN_W;
  endfunction

  function automatic int fall_edges();
    return SYNC + HOLD;
  endfunction

  function automatic logic qualifies(int w);
    return (w >= MIN_W);
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(logic act, logic exp, string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", what, act, exp);
    end
  endtask

  task automatic pulse_hard(int w);
    hard_n = 1'b0;
    step(w);
    hard_n = 1'b1;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic any;
    void'($urandom(32'd4242));

    // R1: asynchronous power-on assertion before any clock edge
    #1 por_n = 1'b0;
    #1;
    chk(hard_pull_en, 1'b1, "R1 hard pin on por");
    chk(soft_pull_en, 1'b1, "R1 soft pin on por");
    chk(core_rst,     1'b1, "R1 core on por");
    step(20);
    por_n = 1'b1;
    // R2: release timing after power-on
    step(fall_edges() - 1);
    chk(hard_pull_en & soft_pull_en & core_rst, 1'b1, "R2 held last cycle");
    step(1);
    chk(hard_pull_en | soft_pull_en | core_rst, 1'b0, "R2 released");
    step(10);

    // R3: 3-cycle glitch rejected
    pulse_hard(3);
    any = 1'b0;
    for (int i = 0; i < 12; i++) begin
      step(1);
      any |= hard_pull_en | soft_pull_en | core_rst;
    end
    chk(any, 1'b0, "R3 hard glitch ignored");

    // R4/R5: minimum qualifying hard pulse
    hard_n = 1'b0;
    step(MIN_W);
    hard_n = 1'b1;
    step(rise_edges() - MIN_W - 1);
    chk(hard_pull_en, 1'b0, "R4 hard not yet asserted");
    step(1);
    chk(hard_pull_en, 1'b1, "R4 hard asserted");
    chk(soft_pull_en, 1'b1, "R6 soft follows hard");
    chk(core_rst,     1'b1, "R4 core asserted");
    step(fall_edges() - 1 - (rise_edges() - MIN_W));
    chk(hard_pull_en & core_rst & soft_pull_en, 1'b1, "R5 held last cycle");
    step(1);
    chk(hard_pull_en | core_rst | soft_pull_en, 1'b0, "R5 released");
    step(10);

    // R7/R4/R5: soft pulse of 8
    any = 1'b0;
    soft_n = 1'b0;
    for (int i = 1; i <= 8; i++) begin
      step(1);
      any |= hard_pull_en | core_rst;
      if (i == rise_edges() - 1) chk(soft_pull_en, 1'b0, "R4 soft not yet");
      if (i == rise_edges())     chk(soft_pull_en, 1'b1, "R4 soft asserted");
    end
    soft_n = 1'b1;
    for (int j = 1; j <= fall_edges(); j++) begin
      step(1);
      any |= hard_pull_en | core_rst;
      if (j == fall_edges() - 1) chk(soft_pull_en, 1'b1, "R5 soft held");
      if (j == fall_edges())     chk(soft_pull_en, 1'b0, "R5 soft released");
    end
    chk(any, 1'b0, "R7 soft kept out of hard domain");
    step(10);

    // R8: retrigger restarts hold
    pulse_hard(4);
    step(1000);
    pulse_hard(5);
    step(fall_edges() - 1);
    chk(hard_pull_en, 1'b1, "R8 hold restarted");
    step(1);
    chk(hard_pull_en | core_rst, 1'b0, "R8 release from second request");
    step(10);

    // R9/R1: power-on during hard hold
    pulse_hard(4);
    step(100);
    por_n = 1'b0;
    #1;
    chk(hard_pull_en & soft_pull_en & core_rst, 1'b1, "R1 por during hold");
    step(4);
    por_n = 1'b1;
    step(fall_edges() - 1);
    chk(hard_pull_en & soft_pull_en & core_rst, 1'b1, "R9 held from por release");
    step(1);
    chk(hard_pull_en | soft_pull_en | core_rst, 1'b0, "R9 released");
    step(10);

    // R10: soft during hard hold
    pulse_hard(4);
    step(2);
    soft_n = 1'b0;
    step(6);
    soft_n = 1'b1;
    step(fall_edges() - 1 - 8);
    chk(hard_pull_en & core_rst, 1'b1, "R10 hard held");
    step(1);
    chk(hard_pull_en | core_rst, 1'b0, "R10 hard released on time");
    chk(soft_pull_en, 1'b1, "R10 soft extended");
    step(7);
    chk(soft_pull_en, 1'b1, "R10 soft held last cycle");
    step(1);
    chk(soft_pull_en, 1'b0, "R10 soft released");
    step(10);

    // R3/R4: random soft widths
    for (int k = 0; k < 6; k++) begin
      int w;
      w = 1 + int'($urandom_range(0, 6));
      soft_n = 1'b0;
      step(w);
      soft_n = 1'b1;
      step(3);
      chk(soft_pull_en, qualifies(w), $sformatf("R3/R4 soft width %0d", w));
      step(fall_edges() + 2);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule